// File: doc/BRIEF.md
# Set-Associative Address Translation Cache

This block keeps a small store of recent virtual-to-physical page translations so that most address lookups finish without touching the page table in memory. A requester presents an 8-bit virtual page number (VPN) on a valid/ready request channel. The block selects one of four sets from the VPN and compares the stored tags of all four ways of that set in parallel. When a way matches, the block returns its 6-bit physical page number (PPN) and its 3 permission bits one cycle after the request was accepted.

When no way matches, the block issues a page-table walk request on a second valid/ready channel and waits for the walker's answer on a third one. A good answer is returned to the requester and written into the set, into an empty way if one exists and otherwise into the way named by that set's rotating pointer. An answer that reports a page fault is passed on but never stored. A flush input, pulsed on a context switch, empties the whole store in one cycle.

Back-pressure rules: the request channel accepts only while the block is idle and no flush is present, so the requester holds `req_valid_i` and `req_vpn_i` until `req_ready_o` is high. The walk request is held stable until the walker raises `walk_req_ready_i`. The walker may present its answer only while `walk_rsp_ready_o` is high. The response channel has no ready: it is a one-cycle pulse that the requester must take.

Top module: `xlat_cache`

## Requirements
- R1: After reset, no entry is valid, `req_ready_o` is 1, and `resp_valid_o` and `walk_req_valid_o` are 0. The first lookup of any VPN misses.
- R2: The set is chosen by VPN bits [1:0] and the tag is VPN bits [7:2]. VPNs that share a set but differ in tag, or share a tag but differ in set, occupy separate entries and never return each other's data.
- R3: A lookup that hits raises `resp_valid_o` in the cycle right after acceptance with `resp_hit_o`=1, `resp_fault_o`=0, and the stored PPN and permissions. Permission bit 0 means read, bit 1 means write, and bit 2 means supervisor. No walk request is issued.
- R4: A lookup that misses raises `walk_req_valid_o` in the cycle after acceptance, with `walk_req_vpn_o` equal to the VPN. Both are held until the walker accepts. `req_ready_o` stays 0 from then until the response.
- R5: After the walk request is taken, `walk_rsp_ready_o` is 1. One cycle after the walker's answer is accepted, `resp_valid_o` pulses with `resp_hit_o`=0 and the walker's fault flag, PPN and permissions. A non-faulting answer is stored, so a repeat lookup hits.
- R6: A walker answer with the fault flag set is never stored. A repeat lookup of that VPN misses again.
- R7: A fill takes the lowest-numbered invalid way of its set. If all four are valid, it takes the way named by the set's pointer. Each pointer starts at 0 after reset and advances by one, wrapping, each time it is used.
- R8: A flush pulse clears every entry, so all later lookups miss. `req_ready_o` is 0 during the flush cycle.
- R9: If a flush coincides with acceptance of a walker answer, the answer is still returned, but nothing is stored and no entry is valid afterwards.
- R10: No more than one way of a set ever matches a lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Invalidate every entry (context switch) |
| req_valid_i | input | 1 | Lookup request valid |
| req_ready_o | output | 1 | Lookup request can be accepted |
| req_vpn_i | input | 8 | Virtual page number to translate |
| resp_valid_o | output | 1 | One-cycle result pulse |
| resp_hit_o | output | 1 | Result came from the store |
| resp_fault_o | output | 1 | Walker reported a page fault |
| resp_ppn_o | output | 6 | Physical page number |
| resp_perm_o | output | 3 | Permissions {supervisor, write, read} |
| walk_req_valid_o | output | 1 | Page-table walk request valid |
| walk_req_ready_i | input | 1 | Walker accepts the request |
| walk_req_vpn_o | output | 8 | VPN to walk |
| walk_rsp_valid_i | input | 1 | Walker answer valid |
| walk_rsp_ready_o | output | 1 | Block accepts the walker answer |
| walk_rsp_fault_i | input | 1 | Answer is a page fault |
| walk_rsp_ppn_i | input | 6 | PPN from the page table |
| walk_rsp_perm_i | input | 3 | Permissions from the page table |

## Verification
Some properties are checked by assertions on every cycle. At most one way of a set matches a lookup. An accepted request is always followed in the next cycle by a response or a walk request. A stalled walk request keeps its VPN stable, and `req_ready_o` stays low while it is outstanding. A faulting answer leaves the valid bits unchanged. A flush, including one that coincides with a fill, leaves no entry valid. A fill never lands on a valid way while the set still has an invalid one. Other behaviour can only be shown by the bench's scenarios, checked against a reference model: which way a full set gives up under the rotating pointer, the exact tag and set split, and whether entries survive or vanish over a sequence of fills, evictions and flushes.

// File: rtl/xlat_pkg.sv
`timescale 1ns/1ps
package xlat_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WREQ = 2'd1,
    ST_WAIT = 2'd2
  } seq_state_t;
endpackage

// File: rtl/xlat_store.sv
`timescale 1ns/1ps
module xlat_store #(
  parameter int SETS   = 4,
  parameter int WAYS   = 4,
  parameter int TAG_W  = 6,
  parameter int PPN_W  = 6,
  parameter int PERM_W = 3,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        flush_i,
  input  logic [SET_W-1:0]            lk_set_i,
  input  logic [TAG_W-1:0]            lk_tag_i,
  output logic [WAYS-1:0]             lk_hit_vec_o,
  output logic [PPN_W-1:0]            lk_ppn_o,
  output logic [PERM_W-1:0]           lk_perm_o,
  input  logic                        wr_en_i,
  input  logic [SET_W-1:0]            wr_set_i,
  input  logic [WAY_W-1:0]            wr_way_i,
  input  logic [TAG_W-1:0]            wr_tag_i,
  input  logic [PPN_W-1:0]            wr_ppn_i,
  input  logic [PERM_W-1:0]           wr_perm_i,
  output logic [SETS-1:0][WAYS-1:0]   valid_o
);
  logic [SETS-1:0][WAYS-1:0] valid_q;
  logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
  logic [PPN_W-1:0]  ppn_q  [SETS][WAYS];
  logic [PERM_W-1:0] perm_q [SETS][WAYS];

  // Valid bits: flush has priority over a fill in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n || flush_i) begin
      valid_q <= '0;
    end else if (wr_en_i) begin
      valid_q[wr_set_i][wr_way_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en_i) begin
      tag_q[wr_set_i][wr_way_i]  <= wr_tag_i;
      ppn_q[wr_set_i][wr_way_i]  <= wr_ppn_i;
      perm_q[wr_set_i][wr_way_i] <= wr_perm_i;
    end
  end

  // Parallel tag compare across all ways of the indexed set.
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign lk_hit_vec_o[w] = valid_q[lk_set_i][w] && (tag_q[lk_set_i][w] == lk_tag_i);
  end

  always_comb begin
    lk_ppn_o  = '0;
    lk_perm_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (lk_hit_vec_o[w]) begin
        lk_ppn_o  = lk_ppn_o  | ppn_q[lk_set_i][w];
        lk_perm_o = lk_perm_o | perm_q[lk_set_i][w];
      end
    end
  end

  assign valid_o = valid_q;

  // R10: never more than one matching way
  a_r10_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_hit_vec_o));

  // R8: a flush leaves every entry invalid
  a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (valid_q == '0));

  // R9: flush together with a fill still leaves nothing valid
  a_r9_flush_beats_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_i && wr_en_i) |=> (valid_q == '0));
endmodule

// File: rtl/xlat_victim.sv
`timescale 1ns/1ps
module xlat_victim #(
  parameter int SETS = 4,
  parameter int WAYS = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] set_i,
  input  logic [WAYS-1:0]  row_valid_i,
  input  logic             adv_i,
  output logic [WAY_W-1:0] way_o
);
  logic [SETS*WAY_W-1:0] ptr_flat;
  logic [WAY_W-1:0]      ptr_sel;
  logic                  row_full;

  assign row_full = &row_valid_i;
  assign ptr_sel  = ptr_flat[set_i*WAY_W +: WAY_W];

  // One rotating pointer per set, advanced only when it chose the victim.
  for (genvar s = 0; s < SETS; s++) begin : g_ptr
    logic [WAY_W-1:0] ptr_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ptr_q <= '0;
      end else if (adv_i && row_full && (set_i == SET_W'(s))) begin
        ptr_q <= ptr_q + 1'b1;
      end
    end
    assign ptr_flat[s*WAY_W +: WAY_W] = ptr_q;
  end

  // Lowest-numbered invalid way wins; otherwise the pointer decides.
  always_comb begin
    logic found;
    found = 1'b0;
    way_o = ptr_sel;
    for (int w = 0; w < WAYS; w++) begin
      if (!found && !row_valid_i[w]) begin
        way_o = WAY_W'(w);
        found = 1'b1;
      end
    end
  end

  // R7: a fill never overwrites a valid way while an invalid one remains
  a_r7_invalid_first: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !row_full) |-> !row_valid_i[way_o]);
endmodule

// File: rtl/xlat_seq.sv
`timescale 1ns/1ps
module xlat_seq
  import xlat_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic flush_i,
  input  logic req_valid_i,
  input  logic lk_hit_i,
  input  logic walk_req_ready_i,
  input  logic walk_rsp_valid_i,
  output logic req_ready_o,
  output logic walk_req_valid_o,
  output logic walk_rsp_ready_o
);
  seq_state_t state_q, state_d;

  assign req_ready_o      = (state_q == ST_IDLE) && !flush_i;
  assign walk_req_valid_o = (state_q == ST_WREQ);
  assign walk_rsp_ready_o = (state_q == ST_WAIT);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_valid_i && req_ready_o && !lk_hit_i) state_d = ST_WREQ;
      ST_WREQ: if (walk_req_ready_i) state_d = ST_WAIT;
      ST_WAIT: if (walk_rsp_valid_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // R4: no new request is taken while a walk is outstanding
  a_r4_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req_valid_o || walk_rsp_ready_o) |-> !req_ready_o);
endmodule

// File: rtl/xlat_cache.sv
`timescale 1ns/1ps
module xlat_cache #(
  parameter int VPN_W  = 8,
  parameter int SETS   = 4,
  parameter int WAYS   = 4,
  parameter int PPN_W  = 6,
  parameter int PERM_W = 3,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int TAG_W = VPN_W - SET_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [VPN_W-1:0]  req_vpn_i,
  output logic              resp_valid_o,
  output logic              resp_hit_o,
  output logic              resp_fault_o,
  output logic [PPN_W-1:0]  resp_ppn_o,
  output logic [PERM_W-1:0] resp_perm_o,
  output logic              walk_req_valid_o,
  input  logic              walk_req_ready_i,
  output logic [VPN_W-1:0]  walk_req_vpn_o,
  input  logic              walk_rsp_valid_i,
  output logic              walk_rsp_ready_o,
  input  logic              walk_rsp_fault_i,
  input  logic [PPN_W-1:0]  walk_rsp_ppn_i,
  input  logic [PERM_W-1:0] walk_rsp_perm_i
);
  logic [WAYS-1:0]           hit_vec;
  logic                      hit_any;
  logic [PPN_W-1:0]          lk_ppn;
  logic [PERM_W-1:0]         lk_perm;
  logic [SETS-1:0][WAYS-1:0] valid_bits;
  logic [VPN_W-1:0]          pend_vpn_q;
  logic [SET_W-1:0]          fill_set;
  logic [WAY_W-1:0]          fill_way;
  logic                      req_fire, rsp_fire, fill_en;

  assign hit_any  = |hit_vec;
  assign req_fire = req_valid_i && req_ready_o;
  assign rsp_fire = walk_rsp_valid_i && walk_rsp_ready_o;
  assign fill_en  = rsp_fire && !walk_rsp_fault_i;
  assign fill_set = pend_vpn_q[SET_W-1:0];
  assign walk_req_vpn_o = pend_vpn_q;

  xlat_seq u_seq (
    .clk              (clk),
    .rst_n            (rst_n),
    .flush_i          (flush_i),
    .req_valid_i      (req_valid_i),
    .lk_hit_i         (hit_any),
    .walk_req_ready_i (walk_req_ready_i),
    .walk_rsp_valid_i (walk_rsp_valid_i),
    .req_ready_o      (req_ready_o),
    .walk_req_valid_o (walk_req_valid_o),
    .walk_rsp_ready_o (walk_rsp_ready_o)
  );

  xlat_store #(
    .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .PPN_W(PPN_W), .PERM_W(PERM_W)
  ) u_store (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush_i      (flush_i),
    .lk_set_i     (req_vpn_i[SET_W-1:0]),
    .lk_tag_i     (req_vpn_i[VPN_W-1:SET_W]),
    .lk_hit_vec_o (hit_vec),
    .lk_ppn_o     (lk_ppn),
    .lk_perm_o    (lk_perm),
    .wr_en_i      (fill_en),
    .wr_set_i     (fill_set),
    .wr_way_i     (fill_way),
    .wr_tag_i     (pend_vpn_q[VPN_W-1:SET_W]),
    .wr_ppn_i     (walk_rsp_ppn_i),
    .wr_perm_i    (walk_rsp_perm_i),
    .valid_o      (valid_bits)
  );

  xlat_victim #(.SETS(SETS), .WAYS(WAYS)) u_victim (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_i       (fill_set),
    .row_valid_i (valid_bits[fill_set]),
    .adv_i       (fill_en && !flush_i),
    .way_o       (fill_way)
  );

  // Registered result: hits one cycle after acceptance, misses one cycle after the walk answer.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid_o <= 1'b0;
      resp_hit_o   <= 1'b0;
      resp_fault_o <= 1'b0;
      resp_ppn_o   <= '0;
      resp_perm_o  <= '0;
      pend_vpn_q   <= '0;
    end else begin
      resp_valid_o <= 1'b0;
      if (req_fire && hit_any) begin
        resp_valid_o <= 1'b1;
        resp_hit_o   <= 1'b1;
        resp_fault_o <= 1'b0;
        resp_ppn_o   <= lk_ppn;
        resp_perm_o  <= lk_perm;
      end else if (rsp_fire) begin
        resp_valid_o <= 1'b1;
        resp_hit_o   <= 1'b0;
        resp_fault_o <= walk_rsp_fault_i;
        resp_ppn_o   <= walk_rsp_ppn_i;
        resp_perm_o  <= walk_rsp_perm_i;
      end
      if (req_fire && !hit_any) pend_vpn_q <= req_vpn_i;
    end
  end

  // R3: every accepted request yields a response or a walk request next cycle
  a_r3_prompt_answer: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> (resp_valid_o || walk_req_valid_o));

  // R4: a stalled walk request stays up with a stable VPN
  a_r4_walk_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req_valid_o && !walk_req_ready_i) |=> (walk_req_valid_o && $stable(walk_req_vpn_o)));

  // R6: a faulting answer changes no valid bit
  a_r6_fault_no_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fire && walk_rsp_fault_i && !flush_i) |=> $stable(valid_bits));

  // R5: a response pulse is never issued while waiting on the walker
  a_r5_no_resp_mid_walk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req_valid_o |-> !resp_valid_o);
endmodule

// File: tb/tb_xlat_cache.sv
`timescale 1ns/1ps
module tb_xlat_cache;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       flush_i = 1'b0;
  logic       req_valid_i = 1'b0;
  logic       req_ready_o;
  logic [7:0] req_vpn_i = '0;
  logic       resp_valid_o, resp_hit_o, resp_fault_o;
  logic [5:0] resp_ppn_o;
  logic [2:0] resp_perm_o;
  logic       walk_req_valid_o;
  logic       walk_req_ready_i = 1'b0;
  logic [7:0] walk_req_vpn_o;
  logic       walk_rsp_valid_i = 1'b0;
  logic       walk_rsp_ready_o;
  logic       walk_rsp_fault_i = 1'b0;
  logic [5:0] walk_rsp_ppn_i = '0;
  logic [2:0] walk_rsp_perm_i = '0;

  always #10 clk = ~clk;

  xlat_cache dut (.*);

  int checks = 0;
  int errors = 0;

  // Reference model of the store.
  bit         mv   [4][4];
  logic [5:0] mt   [4][4];
  logic [5:0] mp   [4][4];
  logic [2:0] mperm[4][4];
  int         mrr  [4];

  // Scoreboard queues.
  bit         q_hit[$];
  bit         q_fault[$];
  logic [5:0] q_ppn[$];
  logic [2:0] q_perm[$];
  string      q_req[$];

  function automatic logic [5:0] pt_ppn(input logic [7:0] v);
    return 6'((v * 5 + 3) & 8'h3f);
  endfunction
  function automatic logic [2:0] pt_perm(input logic [7:0] v);
    return {v[0], v[3], 1'b1};
  endfunction
  function automatic bit pt_fault(input logic [7:0] v);
    return v[7:5] == 3'b111;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int s = 0; s < 4; s++)
      for (int w = 0; w < 4; w++) mv[s][w] = 1'b0;
  endtask

  // Driver: one full lookup, playing the walker on a miss.
  task automatic do_lookup(input logic [7:0] vpn, input int stall, input bit flush_fill, input string rq);
    int s;
    int wh;
    s = int'(vpn[1:0]);
    wh = -1;
    for (int w = 0; w < 4; w++)
      if (mv[s][w] && mt[s][w] == vpn[7:2]) wh = w;
    @(negedge clk);
    chk(req_ready_o == 1'b1, rq, "req_ready before request", int'(req_ready_o), 1);
    req_valid_i = 1'b1;
    req_vpn_i   = vpn;
    if (wh >= 0) begin
      q_hit.push_back(1'b1); q_fault.push_back(1'b0);
      q_ppn.push_back(mp[s][wh]); q_perm.push_back(mperm[s][wh]);
    end else begin
      q_hit.push_back(1'b0); q_fault.push_back(pt_fault(vpn));
      q_ppn.push_back(pt_ppn(vpn)); q_perm.push_back(pt_perm(vpn));
    end
    q_req.push_back(rq);
    @(negedge clk);
    req_valid_i = 1'b0;
    if (wh >= 0) begin
      chk(walk_req_valid_o == 1'b0, "R3", "no walk on hit", int'(walk_req_valid_o), 0);
    end else begin
      chk(walk_req_valid_o == 1'b1, "R4", "walk request raised", int'(walk_req_valid_o), 1);
      chk(walk_req_vpn_o == vpn, "R4", "walk vpn", int'(walk_req_vpn_o), int'(vpn));
      chk(req_ready_o == 1'b0, "R4", "req_ready low while busy", int'(req_ready_o), 0);
      for (int i = 0; i < stall; i++) begin
        @(negedge clk);
        chk(walk_req_valid_o == 1'b1 && walk_req_vpn_o == vpn, "R4", "walk request held",
            int'(walk_req_vpn_o), int'(vpn));
      end
      walk_req_ready_i = 1'b1;
      @(negedge clk);
      walk_req_ready_i = 1'b0;
      chk(walk_rsp_ready_o == 1'b1, "R5", "walk answer ready", int'(walk_rsp_ready_o), 1);
      walk_rsp_valid_i = 1'b1;
      walk_rsp_fault_i = pt_fault(vpn);
      walk_rsp_ppn_i   = pt_ppn(vpn);
      walk_rsp_perm_i  = pt_perm(vpn);
      flush_i          = flush_fill;
      @(negedge clk);
      walk_rsp_valid_i = 1'b0;
      flush_i          = 1'b0;
      if (flush_fill) begin
        model_clear();
      end else if (!pt_fault(vpn)) begin
        int way;
        way = -1;
        for (int w = 0; w < 4; w++)
          if (way < 0 && !mv[s][w]) way = w;
        if (way < 0) begin
          way = mrr[s];
          mrr[s] = (mrr[s] + 1) % 4;
        end
        mv[s][way] = 1'b1; mt[s][way] = vpn[7:2];
        mp[s][way] = pt_ppn(vpn); mperm[s][way] = pt_perm(vpn);
      end
    end
    while (q_hit.size() != 0) @(negedge clk);
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush_i = 1'b1;
    #1;
    chk(req_ready_o == 1'b0, "R8", "req_ready low during flush", int'(req_ready_o), 0);
    @(negedge clk);
    flush_i = 1'b0;
    model_clear();
  endtask

  // Monitor: pop and compare each response pulse.
  always @(negedge clk) begin
    if (rst_n && resp_valid_o) begin
      if (q_hit.size() == 0) begin
        chk(1'b0, "R3", "unexpected response", 1, 0);
      end else begin
        bit eh, ef;
        logic [5:0] ep;
        logic [2:0] em;
        string rq;
        eh = q_hit.pop_front(); ef = q_fault.pop_front();
        ep = q_ppn.pop_front(); em = q_perm.pop_front(); rq = q_req.pop_front();
        chk(resp_hit_o == eh, rq, "hit flag", int'(resp_hit_o), int'(eh));
        chk(resp_fault_o == ef, rq, "fault flag", int'(resp_fault_o), int'(ef));
        if (!ef) begin
          chk(resp_ppn_o == ep, rq, "ppn", int'(resp_ppn_o), int'(ep));
          chk(resp_perm_o == em, rq, "perm", int'(resp_perm_o), int'(em));
        end
      end
    end
  end

  initial begin
    #3000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model_clear();
    for (int s = 0; s < 4; s++) mrr[s] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(req_ready_o == 1'b1, "R1", "req_ready after reset", int'(req_ready_o), 1);
    chk(resp_valid_o == 1'b0, "R1", "resp_valid after reset", int'(resp_valid_o), 0);
    chk(walk_req_valid_o == 1'b0, "R1", "walk_req_valid after reset", int'(walk_req_valid_o), 0);
    do_lookup(8'h00, 0, 1'b0, "R1");   // first lookup misses
    do_lookup(8'h00, 0, 1'b0, "R5");   // installed, now hits
    // R2: same set different tag, same tag different set
    do_lookup(8'h04, 0, 1'b0, "R2");
    do_lookup(8'h01, 1, 1'b0, "R2");
    do_lookup(8'h00, 0, 1'b0, "R2");
    do_lookup(8'h04, 0, 1'b0, "R2");
    do_lookup(8'h01, 0, 1'b0, "R3");
    // R6: fault never stored
    do_lookup(8'hE0, 0, 1'b0, "R6");
    do_lookup(8'hE0, 0, 1'b0, "R6");
    // R7: fill set 0, then force rotation
    do_lookup(8'h08, 0, 1'b0, "R7");
    do_lookup(8'h0C, 0, 1'b0, "R7");
    do_lookup(8'h10, 0, 1'b0, "R7");   // evicts way 0 (0x00)
    do_lookup(8'h04, 0, 1'b0, "R7");   // still present
    do_lookup(8'h00, 0, 1'b0, "R7");   // evicted: miss, replaces way 1 (0x04)
    do_lookup(8'h04, 0, 1'b0, "R7");   // miss, replaces way 2 (0x08)
    do_lookup(8'h0C, 0, 1'b0, "R10");
    do_lookup(8'h10, 0, 1'b0, "R10");
    do_lookup(8'h08, 3, 1'b0, "R7");   // miss with back-pressure on the walk request
    do_lookup(8'h01, 0, 1'b0, "R2");
    // R8: flush clears everything
    do_flush();
    do_lookup(8'h01, 0, 1'b0, "R8");
    do_lookup(8'h10, 0, 1'b0, "R8");
    // R9: flush during fill
    do_lookup(8'h21, 2, 1'b1, "R9");
    do_lookup(8'h21, 0, 1'b0, "R9");
    do_lookup(8'h01, 0, 1'b0, "R9");
    // Mixed traffic
    for (int i = 0; i < 24; i++) begin
      do_lookup(8'((i * 37) % 64), i % 3, 1'b0, "R5");
    end
    repeat (3) @(negedge clk);
    chk(q_hit.size() == 0, "R5", "all responses delivered", q_hit.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule